// File: doc/BRIEF.md
# Reset-Cause Status and Sleep Control Register

This block is an 8-bit system status and control register on a simple peripheral bus. The bus has a select, a write strobe, write data and read data. The register records which kind of reset happened last: a cold reset (power-on or external) or a watchdog reset. It also holds a one-way watchdog enable. Software can clear that enable bit, but it cannot set it again.

The register drives a sleep request to a power-down sequencer and a halt request to the CPU. An enabled interrupt cancels the sleep request, but only after the sequencer has reported that its power-down step is complete. An interrupt that arrives earlier is held back until then.

All three reset inputs are synchronous, active-high pulses. They are sampled on the rising clock edge like any other input.

Top module: `sys_status_ctl`

## Requirements
- R1: A cold reset (`por_i` or `xrst_i` high at a clock edge) leaves the register reading 0x10 while `gie_i` is low. It also leaves `wdt_en_o`, `sleep_req_o` and `halt_o` low.
- R2: A watchdog reset (`wdr_i`) leaves the register reading 0x20 while `gie_i` is low. If a cold reset is asserted in the same cycle, the cold reset wins and the register reads 0x10.
- R3: Bit 7 always shows the current `gie_i` level, and writes to it are ignored. Bits 6, 2 and 1 always read 0, whatever is written to them.
- R4: Bit 5 (the watchdog-cause flag) is set only by a watchdog reset. A write with 0 in bit 5 clears it. A write with 1 in bit 5 leaves it unchanged.
- R5: Bit 4 (the cold-cause flag) is cleared by a write with 0 in bit 4, and no write can set it. `wdt_en_o` is the inverse of bit 4. Once high, `wdt_en_o` stays high through watchdog resets until the next cold reset.
- R6: A write with 1 in bit 3 sets bit 3 and `sleep_req_o` at that clock edge. This does not happen if `irq_at_boundary_i` is high in the write cycle; the write then leaves bit 3 unchanged. A write with 0 in bit 3 has no effect on bit 3.
- R7: While bit 3 is set, `irq_en_i` is held off until `sleep_done_i` has been seen. An interrupt that arrives before the done pulse makes bit 3 fall at the second clock edge after the done pulse. An interrupt that arrives after the done pulse clears bit 3 at the edge that samples it.
- R8: Bit 0 is read/write and drives `halt_o`. Any reset, including a watchdog reset, clears it.
- R9: `rdata_o` shows the register only while `sel_i` is high and reads 0 otherwise. A write takes effect only when `sel_i` and `wr_i` are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset pulse, synchronous |
| xrst_i | input | 1 | External reset pulse, synchronous |
| wdr_i | input | 1 | Watchdog reset pulse, synchronous |
| sel_i | input | 1 | Register select |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| gie_i | input | 1 | CPU global interrupt enable level |
| irq_at_boundary_i | input | 1 | An interrupt will be taken at the current instruction boundary |
| irq_en_i | input | 1 | An enabled interrupt is asserted |
| sleep_done_i | input | 1 | Sequencer pulse: power-down step finished |
| sleep_req_o | output | 1 | Sleep request to the sequencer |
| wdt_en_o | output | 1 | Watchdog enable |
| halt_o | output | 1 | Halt request to the CPU |

## Verification
The assertions treat any cycle with a reset input high as outside their scope. They also assume that `sleep_done_i` only matters while a sleep request is pending. The bench therefore pulses resets for exactly one cycle at a time. It raises `irq_at_boundary_i`, `irq_en_i` and `sleep_done_i` only for single, deliberate cycles.

All inputs change one time unit after the rising edge, so every edge samples settled values. A behavioural model in the bench runs on the same edges. It is compared with all outputs at each falling edge.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    localparam int REG_W = 8;

    // bit positions
    localparam int B_GIE  = 7;
    localparam int B_WDR  = 5;
    localparam int B_COLD = 4;
    localparam int B_SLP  = 3;
    localparam int B_HALT = 0;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_COLD = 2'd1,
        RK_WDOG = 2'd2
    } rst_kind_e;

    typedef struct packed {
        logic             hit;
        logic [REG_W-1:0] data;
    } wr_req_t;

    typedef struct packed {
        logic gie;
        logic wdr_flag;
        logic cold_flag;
        logic slp;
        logic halt;
    } fields_t;

    function automatic rst_kind_e classify(logic por, logic xr, logic wd);
        if (por || xr) return RK_COLD;
        if (wd)        return RK_WDOG;
        return RK_NONE;
    endfunction

    function automatic logic [REG_W-1:0] pack_fields(fields_t f);
        logic [REG_W-1:0] v;
        v         = '0;
        v[B_GIE]  = f.gie;
        v[B_WDR]  = f.wdr_flag;
        v[B_COLD] = f.cold_flag;
        v[B_SLP]  = f.slp;
        v[B_HALT] = f.halt;
        return v;
    endfunction

endpackage

// File: rtl/rsc_cause.sv
module rsc_cause
    import rsc_pkg::*;
(
    input  logic      clk,
    input  rst_kind_e kind_i,
    input  wr_req_t   wr_i,
    output logic      wdr_flag_o,
    output logic      cold_flag_o
);

    logic wdr_q, cold_q;

    always_ff @(posedge clk) begin
        case (kind_i)
            RK_COLD: begin
                wdr_q  <= 1'b0;
                cold_q <= 1'b1;
            end
            RK_WDOG: begin
                wdr_q  <= 1'b1;
                cold_q <= 1'b0;
            end
            default: begin
                if (wr_i.hit) begin
                    if (!wr_i.data[B_WDR])  wdr_q  <= 1'b0;
                    if (!wr_i.data[B_COLD]) cold_q <= 1'b0;
                end
            end
        endcase
    end

    assign wdr_flag_o  = wdr_q;
    assign cold_flag_o = cold_q;

    // R4
    wdr_no_sw_set_chk: assert property (@(posedge clk)
        disable iff (kind_i != RK_NONE) !wdr_q |=> !wdr_q);

    // R5
    cold_no_sw_set_chk: assert property (@(posedge clk)
        disable iff (kind_i == RK_COLD) !cold_q |=> !cold_q);

endmodule

// File: rtl/rsc_sleep.sv
module rsc_sleep
    import rsc_pkg::*;
(
    input  logic      clk,
    input  rst_kind_e kind_i,
    input  wr_req_t   wr_i,
    input  logic      irq_at_boundary_i,
    input  logic      irq_en_i,
    input  logic      sleep_done_i,
    output logic      slp_o
);

    logic slp_q, released_q, held_irq_q;
    logic set_ok, wake;

    assign set_ok = wr_i.hit && wr_i.data[B_SLP] && !irq_at_boundary_i;
    assign wake   = released_q && (held_irq_q || irq_en_i);

    always_ff @(posedge clk) begin
        if (kind_i != RK_NONE) begin
            slp_q      <= 1'b0;
            released_q <= 1'b0;
            held_irq_q <= 1'b0;
        end else if (!slp_q) begin
            if (set_ok) slp_q <= 1'b1;
            released_q <= 1'b0;
            held_irq_q <= 1'b0;
        end else if (wake) begin
            slp_q      <= 1'b0;
            released_q <= 1'b0;
            held_irq_q <= 1'b0;
        end else begin
            if (sleep_done_i) released_q <= 1'b1;
            if (irq_en_i)     held_irq_q <= 1'b1;
        end
    end

    assign slp_o = slp_q;

    // R7
    interlock_hold_chk: assert property (@(posedge clk)
        disable iff (kind_i != RK_NONE) (slp_q && !released_q) |=> slp_q);

    // R7
    released_wake_chk: assert property (@(posedge clk)
        disable iff (kind_i != RK_NONE) (slp_q && released_q && irq_en_i) |=> !slp_q);

    // R6
    blocked_write_chk: assert property (@(posedge clk)
        disable iff (kind_i != RK_NONE) (!slp_q && irq_at_boundary_i) |=> !slp_q);

    // R7
    held_only_in_sleep_chk: assert property (@(posedge clk)
        disable iff (kind_i != RK_NONE) held_irq_q |-> slp_q);

endmodule

// File: rtl/rsc_halt.sv
module rsc_halt
    import rsc_pkg::*;
(
    input  logic      clk,
    input  rst_kind_e kind_i,
    input  wr_req_t   wr_i,
    output logic      halt_o
);

    logic halt_q;

    always_ff @(posedge clk) begin
        if (kind_i != RK_NONE)  halt_q <= 1'b0;
        else if (wr_i.hit)      halt_q <= wr_i.data[B_HALT];
    end

    assign halt_o = halt_q;

    // R8
    halt_wdog_clear_chk: assert property (@(posedge clk)
        disable iff (kind_i == RK_COLD) (kind_i == RK_WDOG) |=> !halt_q);

    // R9
    halt_idle_stable_chk: assert property (@(posedge clk)
        disable iff (kind_i != RK_NONE) !wr_i.hit |=> $stable(halt_q));

endmodule

// File: rtl/sys_status_ctl.sv
module sys_status_ctl
    import rsc_pkg::*;
(
    input  logic             clk,
    input  logic             por_i,
    input  logic             xrst_i,
    input  logic             wdr_i,
    input  logic             sel_i,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] rdata_o,
    input  logic             gie_i,
    input  logic             irq_at_boundary_i,
    input  logic             irq_en_i,
    input  logic             sleep_done_i,
    output logic             sleep_req_o,
    output logic             wdt_en_o,
    output logic             halt_o
);

    rst_kind_e kind;
    wr_req_t   wr;
    fields_t   fld;
    logic      wdr_flag, cold_flag, slp, halt;

    assign kind    = classify(por_i, xrst_i, wdr_i);
    assign wr.hit  = sel_i && wr_i;
    assign wr.data = wdata_i;

    rsc_cause u_cause (
        .clk         (clk),
        .kind_i      (kind),
        .wr_i        (wr),
        .wdr_flag_o  (wdr_flag),
        .cold_flag_o (cold_flag)
    );

    rsc_sleep u_sleep (
        .clk               (clk),
        .kind_i            (kind),
        .wr_i              (wr),
        .irq_at_boundary_i (irq_at_boundary_i),
        .irq_en_i          (irq_en_i),
        .sleep_done_i      (sleep_done_i),
        .slp_o             (slp)
    );

    rsc_halt u_halt (
        .clk    (clk),
        .kind_i (kind),
        .wr_i   (wr),
        .halt_o (halt)
    );

    assign fld.gie       = gie_i;
    assign fld.wdr_flag  = wdr_flag;
    assign fld.cold_flag = cold_flag;
    assign fld.slp       = slp;
    assign fld.halt      = halt;

    assign rdata_o     = sel_i ? pack_fields(fld) : '0;
    assign sleep_req_o = slp;
    assign wdt_en_o    = !cold_flag;
    assign halt_o      = halt;

    // R5
    wdt_sticky_chk: assert property (@(posedge clk)
        disable iff (por_i || xrst_i) wdt_en_o |=> wdt_en_o);

    // R1
    cold_outputs_chk: assert property (@(posedge clk)
        (por_i || xrst_i) |=> (!wdt_en_o && !sleep_req_o && !halt_o));

endmodule

// File: tb/sys_status_ctl_tb.sv
`timescale 1ns/1ps
module sys_status_ctl_tb_top;

    logic       clk = 1'b0;
    logic       por_i = 1'b1, xrst_i = 1'b0, wdr_i = 1'b0;
    logic       sel_i = 1'b1, wr_i = 1'b0;
    logic [7:0] wdata_i = 8'h00;
    logic [7:0] rdata_o;
    logic       gie_i = 1'b0, irq_at_boundary_i = 1'b0, irq_en_i = 1'b0, sleep_done_i = 1'b0;
    logic       sleep_req_o, wdt_en_o, halt_o;

    int  errors = 0;
    int  checks = 0;
    int  cyc = 0;
    bit  started = 1'b0;
    bit  finished = 1'b0;

    // behavioural reference state
    bit m_wdr, m_cold, m_slp, m_rel, m_held, m_halt, m_we;

    always #2.5 clk = ~clk;

    sys_status_ctl dut_i (
        .clk(clk), .por_i(por_i), .xrst_i(xrst_i), .wdr_i(wdr_i),
        .sel_i(sel_i), .wr_i(wr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .gie_i(gie_i), .irq_at_boundary_i(irq_at_boundary_i), .irq_en_i(irq_en_i),
        .sleep_done_i(sleep_done_i), .sleep_req_o(sleep_req_o),
        .wdt_en_o(wdt_en_o), .halt_o(halt_o)
    );

    always @(posedge clk) begin
        cyc++;
        m_we = sel_i && wr_i;
        if (por_i || xrst_i) begin
            m_wdr = 0; m_cold = 1; m_slp = 0; m_rel = 0; m_held = 0; m_halt = 0;
        end else if (wdr_i) begin
            m_wdr = 1; m_cold = 0; m_slp = 0; m_rel = 0; m_held = 0; m_halt = 0;
        end else begin
            if (m_we && !wdata_i[5]) m_wdr = 0;
            if (m_we && !wdata_i[4]) m_cold = 0;
            if (m_we) m_halt = wdata_i[0];
            if (!m_slp) begin
                if (m_we && wdata_i[3] && !irq_at_boundary_i) m_slp = 1;
            end else if (m_rel && (m_held || irq_en_i)) begin
                m_slp = 0; m_rel = 0; m_held = 0;
            end else begin
                if (sleep_done_i) m_rel = 1;
                if (irq_en_i) m_held = 1;
            end
        end
    end

    function automatic logic [7:0] exp_rd();
        if (!sel_i) return 8'h00;
        return {gie_i, 1'b0, m_wdr, m_cold, m_slp, 2'b00, m_halt};
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // compare against the model on every falling edge
    always @(negedge clk) begin
        if (started && !finished) begin
            check("R9 model rdata", rdata_o, exp_rd());
            check("R5 model wdt_en", {7'd0, wdt_en_o}, {7'd0, !m_cold});
            check("R7 model sleep_req", {7'd0, sleep_req_o}, {7'd0, m_slp});
            check("R8 model halt", {7'd0, halt_o}, {7'd0, m_halt});
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic bus_write(logic [7:0] d);
        step(); wr_i = 1'b1; wdata_i = d;
        step(); wr_i = 1'b0;
    endtask

    task automatic rd_check(string tag, logic [7:0] exp);
        @(negedge clk);
        check(tag, rdata_o, exp);
    endtask

    task automatic pin_check(string tag, logic act, logic exp);
        @(negedge clk);
        check(tag, {7'd0, act}, {7'd0, exp});
    endtask

    initial begin
        step(); step(); por_i = 1'b0;
        started = 1'b1;
        rd_check("R1 cold value", 8'h10);
        pin_check("R1 wdt_en low", wdt_en_o, 1'b0);

        bus_write(8'h30);
        rd_check("R4 write one keeps bit5 clear", 8'h10);

        gie_i = 1'b1;
        bus_write(8'hD6);
        rd_check("R3 gie mirror, unused bits zero", 8'h90);
        gie_i = 1'b0;

        bus_write(8'h00);
        rd_check("R5 clear cold flag", 8'h00);
        pin_check("R5 wdt enabled", wdt_en_o, 1'b1);
        bus_write(8'h10);
        rd_check("R5 cold flag cannot be set", 8'h00);

        step(); wdr_i = 1'b1; step(); wdr_i = 1'b0;
        rd_check("R2 watchdog value", 8'h20);
        pin_check("R5 wdt stays on after watchdog", wdt_en_o, 1'b1);

        bus_write(8'h20);
        rd_check("R4 write one keeps bit5 set", 8'h20);
        bus_write(8'h00);
        rd_check("R4 write zero clears bit5", 8'h00);

        bus_write(8'h01);
        pin_check("R8 halt set", halt_o, 1'b1);
        bus_write(8'h00);
        pin_check("R8 halt cleared by write", halt_o, 1'b0);
        bus_write(8'h01);
        step(); wdr_i = 1'b1; step(); wdr_i = 1'b0;
        pin_check("R8 halt cleared by watchdog", halt_o, 1'b0);

        irq_at_boundary_i = 1'b1;
        bus_write(8'h28);
        irq_at_boundary_i = 1'b0;
        rd_check("R6 blocked sleep write", 8'h20);
        bus_write(8'h28);
        rd_check("R6 sleep set", 8'h28);
        bus_write(8'h20);
        rd_check("R6 write zero keeps sleep", 8'h28);

        // early interrupt is held
        step(); irq_en_i = 1'b1; step(); irq_en_i = 1'b0;
        step(); step();
        pin_check("R7 early irq held", sleep_req_o, 1'b1);
        step(); sleep_done_i = 1'b1; step(); sleep_done_i = 1'b0;
        pin_check("R7 still set after done edge", sleep_req_o, 1'b1);
        step();
        pin_check("R7 cleared second edge after done", sleep_req_o, 1'b0);

        // interrupt after release
        bus_write(8'h28);
        step(); sleep_done_i = 1'b1; step(); sleep_done_i = 1'b0;
        step(); step();
        pin_check("R7 done alone keeps sleep", sleep_req_o, 1'b1);
        step(); irq_en_i = 1'b1; step(); irq_en_i = 1'b0;
        pin_check("R7 late irq clears at once", sleep_req_o, 1'b0);

        step(); por_i = 1'b1; wdr_i = 1'b1; step(); por_i = 1'b0; wdr_i = 1'b0;
        rd_check("R2 cold wins over watchdog", 8'h10);

        bus_write(8'h00);
        step(); xrst_i = 1'b1; step(); xrst_i = 1'b0;
        rd_check("R1 external reset value", 8'h10);

        step(); sel_i = 1'b0;
        rd_check("R9 unselected reads zero", 8'h00);
        wr_i = 1'b1; wdata_i = 8'h00; step(); wr_i = 1'b0; sel_i = 1'b1;
        rd_check("R9 unselected write ignored", 8'h10);

        step(); step();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        finished = 1'b1;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule